// File: doc/BRIEF.md
# I2S Stereo Transmit Channel

This block is one transmit channel of an I2S serial audio port. Software-side logic presents a left sample and a right sample through two holding-register write strobes that share one data bus. Each write to the right holding register commits a stereo pair to a small transmit FIFO. The left half of the pair is whatever the left holding register last received. The channel then shifts each sample out on a serial data line, most significant bit first. Timing comes from an externally generated serial clock and word-select signal, and both are sampled in the system clock domain.

A 3-bit code selects the word length. Samples sit right-justified in the holding registers, and the channel sends the top bit of the selected length first and zeros after it. Two interrupts report to the host, and each has its own mask. One fires when the FIFO fill level has drained to a programmable trigger level. The other fires when a right-holding write found the FIFO full. That overrun flag stays set until an overrun-clear read strobe arrives. The FIFO can be flushed, but only while the transmit path is not running. A block-level enable gates the channel-level enable, and the channel sends zeros whenever it is idle or has nothing queued.

Top module: `i2s_tx_chan`

## Requirements
- R1: The word-length code selects how many bits each slot carries: 1 gives 12, 2 gives 16, 3 gives 20, 5 gives 32, and 0, 4, 6 and 7 give 24. The sample is taken as right-justified and zero-extended to 32 bits, and bit (length-1) of it is sent first.
- R2: A right-holding write commits the pair {latest left-holding value, written right value} to the FIFO. Left-holding writes on their own enqueue nothing.
- R3: Serial data changes only after a detected falling serial-clock edge. The first bit of a word appears at the first falling edge after the receiver-visible word-select change. Word select low carries the left sample and high carries the right sample.
- R4: Slot bit positions past the selected word length are sent as zero.
- R5: The empty-threshold interrupt is high while the FIFO level is less than or equal to the 4-bit trigger level and the interrupt is unmasked.
- R6: A right-holding write while the FIFO holds DEPTH pairs sets the overrun flag and discards that pair.
- R7: An overrun-clear read strobe clears the overrun flag on the next clock, unless a new overrun occurs in the same cycle.
- R8: A mask input at 1 holds its interrupt low, and 0 lets it through. Masking does not clear the underlying overrun flag.
- R9: A flush strobe empties the FIFO only while the block enable or the channel enable is low. While both are high it is ignored.
- R10: The channel runs only when both the block enable and the channel enable are high. Otherwise it sends zeros and pops nothing.
- R11: A frame that starts while the FIFO is empty sends zeros in both slots.
- R12: After reset the serial output is 0, the overrun interrupt is low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial bit clock from the clock master |
| ws | input | 1 | Word select (0 left, 1 right) |
| blk_en | input | 1 | Transmit block enable |
| ch_en | input | 1 | Channel enable |
| wr_left | input | 1 | Left holding-register write strobe |
| wr_right | input | 1 | Right holding-register write strobe (commits a pair) |
| wr_data | input | 24 | Holding-register write data |
| wlen | input | 3 | Word-length code |
| trig | input | 4 | Empty-threshold trigger level |
| mask_empty | input | 1 | Mask for the empty-threshold interrupt (1 masks) |
| mask_ovr | input | 1 | Mask for the overrun interrupt (1 masks) |
| flush | input | 1 | FIFO flush strobe |
| ovr_rd | input | 1 | Overrun-clear read strobe |
| sd | output | 1 | Serial data out |
| irq_empty | output | 1 | Empty-threshold interrupt |
| irq_ovr | output | 1 | Overrun interrupt |

## Verification
A fault in the FIFO pointers or level shows up in two ways. The empty-threshold interrupt misreports within two clocks of a write or flush, and the looped-back frame a few hundred clocks later has the wrong contents or order. A shift register that is misaligned or wrongly loaded corrupts the first slot sent after enable. The bench's receiver model catches this one frame later, because it decodes every slot independently of the design. A wrong overrun flag, or broken enable gating, shows on the interrupt pins within two clocks, or as non-zero slots in the next frame.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 32;
    localparam int WLEN_W   = 3;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [SLOT_W-1:0]   slot_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef enum logic [WLEN_W-1:0] {
        WL_AUTO = 3'd0,
        WL_12   = 3'd1,
        WL_16   = 3'd2,
        WL_20   = 3'd3,
        WL_24   = 3'd4,
        WL_32   = 3'd5
    } wlen_e;

    // Number of slot bits carried for a word-length code.
    function automatic int unsigned wlen_bits(logic [WLEN_W-1:0] code);
        case (wlen_e'(code))
            WL_12:   return 12;
            WL_16:   return 16;
            WL_20:   return 20;
            WL_32:   return 32;
            default: return 24;
        endcase
    endfunction

    // Place bit (len-1) of the zero-extended sample at the slot MSB.
    function automatic slot_t align_msb(sample_t s, logic [WLEN_W-1:0] code);
        slot_t z;
        z = slot_t'(s);
        return z << (SLOT_W - wlen_bits(code));
    endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo
    import i2s_tx_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  stereo_t       din,
    output stereo_t       dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    stereo_t        mem [DEPTH];
    logic [AW-1:0]  wp;
    logic [AW-1:0]  rp;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign full  = (level == LW'(DEPTH));
    assign empty = (level == '0);
    assign dout  = mem[rp];

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH)) else $error("level past depth"); // R6
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("pop while empty"); // R11
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty) else $error("flush left data"); // R9

endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial
    import i2s_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              ws,
    input  logic              active,
    input  logic [WLEN_W-1:0] wlen,
    input  logic              fifo_empty,
    input  stereo_t           fifo_pair,
    output logic              pop,
    output logic              sd
);

    logic    sclk_q, sclk_qq, ws_q;
    logic    ws_lat, ws_prev;
    logic    fall, rise, start;
    slot_t   shreg;
    sample_t right_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            ws_q    <= 1'b1;
            ws_lat  <= 1'b1;
            ws_prev <= 1'b1;
        end else begin
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            ws_q    <= ws;
            if (rise) ws_lat  <= ws_q;
            if (fall) ws_prev <= ws_lat;
        end
    end

    assign rise  = sclk_q & ~sclk_qq;
    assign fall  = ~sclk_q & sclk_qq;
    assign start = fall & (ws_lat != ws_prev);
    assign pop   = start & ~ws_lat & active & ~fifo_empty;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            shreg      <= '0;
            right_hold <= '0;
        end else if (start) begin
            if (!ws_lat) begin
                shreg      <= pop ? align_msb(fifo_pair.left, wlen) : '0;
                right_hold <= pop ? fifo_pair.right : '0;
            end else begin
                shreg      <= align_msb(right_hold, wlen);
            end
        end else if (fall) begin
            shreg <= {shreg[SLOT_W-2:0], 1'b0};
        end
    end

    assign sd = shreg[SLOT_W-1];

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !active |=> !sd) else $error("data while idle"); // R10
    AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(fall) && !$past(rst)) |-> $stable(sd))
        else $error("data moved without falling edge"); // R3

endmodule

// File: rtl/i2s_tx_chan.sv
module i2s_tx_chan
    import i2s_tx_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int TRIG_W = 4,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              ws,
    input  logic              blk_en,
    input  logic              ch_en,
    input  logic              wr_left,
    input  logic              wr_right,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic [WLEN_W-1:0] wlen,
    input  logic [TRIG_W-1:0] trig,
    input  logic              mask_empty,
    input  logic              mask_ovr,
    input  logic              flush,
    input  logic              ovr_rd,
    output logic              sd,
    output logic              irq_empty,
    output logic              irq_ovr
);

    sample_t       left_hold;
    stereo_t       fifo_in, fifo_out;
    logic [LW-1:0] level;
    logic          fifo_full, fifo_empty;
    logic          active, flush_ok, push, pop, ovr_set, ovr_flag;

    assign active   = blk_en & ch_en;
    assign flush_ok = flush & ~active;
    assign ovr_set  = wr_right & fifo_full;
    assign push     = wr_right & ~fifo_full & ~flush_ok;
    assign fifo_in  = '{left: left_hold, right: wr_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold <= '0;
            ovr_flag  <= 1'b0;
        end else begin
            if (wr_left) left_hold <= wr_data;
            if (ovr_set)     ovr_flag <= 1'b1;
            else if (ovr_rd) ovr_flag <= 1'b0;
        end
    end

    i2s_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .flush (flush_ok),
        .din   (fifo_in),
        .dout  (fifo_out),
        .level (level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    i2s_tx_serial u_serial (
        .clk        (clk),
        .rst        (rst),
        .sclk       (sclk),
        .ws         (ws),
        .active     (active),
        .wlen       (wlen),
        .fifo_empty (fifo_empty),
        .fifo_pair  (fifo_out),
        .pop        (pop),
        .sd         (sd)
    );

    assign irq_empty = ~mask_empty & (32'(level) <= 32'(trig));
    assign irq_ovr   = ~mask_ovr & ovr_flag;

    AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        (wr_right && fifo_full) |=> ovr_flag) else $error("overrun missed"); // R6
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
        (wr_right && fifo_full && !pop && !flush_ok) |=> level == $past(level))
        else $error("full write changed level"); // R6
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ovr_rd && !(wr_right && fifo_full)) |=> !ovr_flag)
        else $error("overrun not cleared"); // R7
    AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (rst)
        (wr_right && !fifo_full && !pop && !flush_ok) |=> level == $past(level) + 1'b1)
        else $error("pair not committed"); // R2

endmodule

// File: tb/test_i2s_tx_chan.sv
module test_i2s_tx_chan;

    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        ws = 1'b1;
    logic        blk_en = 1'b0, ch_en = 1'b0;
    logic        wr_left = 1'b0, wr_right = 1'b0;
    logic [23:0] wr_data = '0;
    logic [2:0]  wlen = '0;
    logic [3:0]  trig = '0;
    logic        mask_empty = 1'b0, mask_ovr = 1'b0;
    logic        flush = 1'b0, ovr_rd = 1'b0;
    logic        sd, irq_empty, irq_ovr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    i2s_tx_chan #(.DEPTH(DEPTH)) i_i2s_tx_chan (
        .clk(clk), .rst(rst), .sclk(sclk), .ws(ws),
        .blk_en(blk_en), .ch_en(ch_en),
        .wr_left(wr_left), .wr_right(wr_right), .wr_data(wr_data),
        .wlen(wlen), .trig(trig),
        .mask_empty(mask_empty), .mask_ovr(mask_ovr),
        .flush(flush), .ovr_rd(ovr_rd),
        .sd(sd), .irq_empty(irq_empty), .irq_ovr(irq_ovr)
    );

    // Clock master: 8 system clocks per bit, 32 bits per slot.
    int div = 0;
    int bitpos = 0;
    always @(posedge clk) begin
        if (div == 3) begin
            div  <= 0;
            sclk <= ~sclk;
            if (sclk) begin
                if (bitpos == 31) begin
                    bitpos <= 0;
                    ws     <= ~ws;
                end else begin
                    bitpos <= bitpos + 1;
                end
            end
        end else begin
            div <= div + 1;
        end
    end

    // Reference receiver: samples on rising serial clock.
    logic [31:0] acc = '0;
    logic [31:0] last_l = '0;
    logic        ws_seen = 1'b1;
    logic [31:0] fl [256];
    logic [31:0] fr [256];
    int          fc = 0;
    always @(posedge sclk) begin
        acc = {acc[30:0], sd};
        if (ws != ws_seen) begin
            if (!ws_seen) begin
                last_l = acc;
            end else begin
                fl[fc % 256] = last_l;
                fr[fc % 256] = acc;
                fc = fc + 1;
            end
            acc     = '0;
            ws_seen = ws;
        end
    end

    function automatic logic [31:0] exp_word(input logic [23:0] s, input int code);
        int n;
        logic [31:0] z, r;
        n = (code == 1) ? 12 : (code == 2) ? 16 : (code == 3) ? 20 : (code == 5) ? 32 : 24;
        z = {8'h00, s};
        r = '0;
        for (int i = 0; i < n; i++) r[31-i] = z[n-1-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_left(input logic [23:0] v);
        wr_left = 1'b1; wr_data = v; tick(1); wr_left = 1'b0;
    endtask

    task automatic put_right(input logic [23:0] v);
        wr_right = 1'b1; wr_data = v; tick(1); wr_right = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1; tick(1); flush = 1'b0;
    endtask

    task automatic wait_frames_to(input int target);
        while (fc < target) tick(1);
    endtask

    task automatic go_idle_and_flush();
        ch_en = 1'b0; blk_en = 1'b1;
        tick(1);
        do_flush();
    endtask

    // Enable during a right slot so the next left slot pops the first pair.
    task automatic enable_aligned(output int f0);
        @(posedge ws);
        tick(1);
        ch_en = 1'b1; blk_en = 1'b1;
        f0 = fc;
    endtask

    task automatic test_reset();
        check("R12 sd", {31'b0, sd}, 32'd0);
        check("R12 irq_ovr", {31'b0, irq_ovr}, 32'd0);
        check("R12 empty level", {31'b0, irq_empty}, 32'd1);
    endtask

    task automatic test_word(input int code, input logic [23:0] l, input logic [23:0] r);
        int f0;
        go_idle_and_flush();
        wlen = 3'(code);
        put_left(24'h5A5A5A);
        put_left(l);
        put_right(r);
        enable_aligned(f0);
        wait_frames_to(f0 + 3);
        check($sformatf("R1 R2 R3 R4 left code %0d", code), fl[(f0+1) % 256], exp_word(l, code));
        check($sformatf("R1 R3 R4 right code %0d", code), fr[(f0+1) % 256], exp_word(r, code));
        check("R11 empty left", fl[(f0+2) % 256], 32'd0);
        check("R11 empty right", fr[(f0+2) % 256], 32'd0);
        ch_en = 1'b0;
    endtask

    task automatic test_threshold();
        go_idle_and_flush();
        trig = 4'd2; mask_empty = 1'b0;
        tick(2);
        check("R5 level0", {31'b0, irq_empty}, 32'd1);
        put_left(24'h1); put_right(24'h2);
        put_left(24'h3); put_right(24'h4);
        tick(2);
        check("R5 level equal trig", {31'b0, irq_empty}, 32'd1);
        put_right(24'h5);
        tick(2);
        check("R5 level above trig", {31'b0, irq_empty}, 32'd0);
        do_flush();
        tick(1);
        mask_empty = 1'b1;
        tick(1);
        check("R8 empty masked", {31'b0, irq_empty}, 32'd0);
        mask_empty = 1'b0;
        trig = 4'd0;
    endtask

    task automatic test_overrun();
        int f0;
        go_idle_and_flush();
        wlen = 3'd4;
        mask_ovr = 1'b0;
        ovr_rd = 1'b1; tick(1); ovr_rd = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            put_left(24'h100000 + 24'(i));
            put_right(24'h200000 + 24'(i));
        end
        tick(2);
        check("R6 no overrun at full", {31'b0, irq_ovr}, 32'd0);
        put_left(24'hEEEEEE);
        put_right(24'hDDDDDD);
        tick(2);
        check("R6 overrun set", {31'b0, irq_ovr}, 32'd1);
        mask_ovr = 1'b1; tick(1);
        check("R8 overrun masked", {31'b0, irq_ovr}, 32'd0);
        mask_ovr = 1'b0; tick(1);
        check("R8 flag kept under mask", {31'b0, irq_ovr}, 32'd1);
        ovr_rd = 1'b1; tick(1); ovr_rd = 1'b0;
        tick(1);
        check("R7 overrun cleared", {31'b0, irq_ovr}, 32'd0);
        enable_aligned(f0);
        wait_frames_to(f0 + DEPTH + 2);
        for (int i = 0; i < DEPTH; i++) begin
            check("R6 kept left", fl[(f0+1+i) % 256], exp_word(24'h100000 + 24'(i), 4));
            check("R6 kept right", fr[(f0+1+i) % 256], exp_word(24'h200000 + 24'(i), 4));
        end
        check("R6 dropped pair absent", fl[(f0+1+DEPTH) % 256] | fr[(f0+1+DEPTH) % 256], 32'd0);
        ch_en = 1'b0;
    endtask

    task automatic test_enable_override();
        int f0;
        blk_en = 1'b0; ch_en = 1'b0;
        tick(1);
        do_flush();
        trig = 4'd0;
        put_left(24'hABCDEF); put_right(24'h123456);
        put_left(24'h654321); put_right(24'hFEDCBA);
        ch_en = 1'b1;
        f0 = fc;
        wait_frames_to(f0 + 3);
        check("R10 block off left zero", fl[(f0+1) % 256], 32'd0);
        check("R10 block off right zero", fr[(f0+2) % 256], 32'd0);
        check("R10 no pop while block off", {31'b0, irq_empty}, 32'd0);
        do_flush();
        tick(1);
        check("R9 flush with block off", {31'b0, irq_empty}, 32'd1);
        ch_en = 1'b0;
    endtask

    task automatic test_flush_gate();
        go_idle_and_flush();
        trig = 4'd0;
        ch_en = 1'b1; blk_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            put_left(24'h000100 + 24'(i));
            put_right(24'h000200 + 24'(i));
        end
        do_flush();
        tick(1);
        check("R9 flush ignored while running", {31'b0, irq_empty}, 32'd0);
        ch_en = 1'b0;
        tick(1);
        do_flush();
        tick(1);
        check("R9 flush with channel off", {31'b0, irq_empty}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(6);
        rst = 1'b0;
        tick(2);
        test_reset();
        test_word(1, 24'hABCDEF, 24'h5A3C96);
        test_word(2, 24'hABCDEF, 24'h5A3C96);
        test_word(3, 24'hABCDEF, 24'h5A3C96);
        test_word(4, 24'hABCDEF, 24'h5A3C96);
        test_word(5, 24'hABCDEF, 24'h5A3C96);
        test_word(0, 24'h800001, 24'h7FFFFE);
        test_threshold();
        test_overrun();
        test_enable_override();
        test_flush_gate();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule